// File: doc/BRIEF.md
# Serial Peripheral Master with Variable Character Size

This block is a master-side serial peripheral engine. It takes one character from a 16-bit parallel word and shifts it out on a clock/data line pair, while it collects the same number of bits from the returning data line. The character size is set per transfer by a 4-bit length code, with character size = code + 1 bits. The bits are always taken from the low end of the word. A direction bit selects whether the least or the most significant bit of the character goes out first.

The serial clock comes from the base clock through a programmable prescaler. Each transfer samples the prescaler, length and direction inputs on its start strobe and holds them until the transfer ends. The transfer follows mode 0: the serial clock rests low, outgoing data changes on falling edges and incoming data is captured on rising edges. A one-cycle completion pulse marks the capture of the final bit, and the received character appears at that time.

Top module: `spi_char_master`

## Requirements
- R1: While reset is held and after it is released, `sck`, `mosi` and `done` are 0 and `rx_word` is 0x0000.
- R2: During a transfer each high and each low phase of `sck` lasts exactly 2*(prescale+1) base-clock cycles, giving a serial period of 4*(prescale+1) cycles at 50% duty. The first low phase counts from the edge that accepts `start`.
- R3: A transfer carries char_len+1 bits for char_len of 3 or more, which means that many rising edges of `sck`.
- R4: A char_len below 3 is handled as a 4-bit character.
- R5: Only the low N bits of `tx_word` are sent (N = character size). The bits above them have no effect on `mosi`.
- R6: msb_first=0 sends bit 0 first and bit N-1 last. msb_first=1 sends bit N-1 first and bit 0 last.
- R7: The first bit is on `mosi` from the clock after `start` is accepted. After that, `mosi` changes only when `sck` falls. `miso` is sampled on each rising edge of `sck`.
- R8: A received bit goes to the same bit position that the bit sent in the same slot was taken from. `rx_word` is right-justified with zeros above bit N-1, and it changes only in the cycle where `done` is high.
- R9: `done` is high for exactly one base-clock cycle, the one that begins with the rising edge of `sck` for the last bit.
- R10: A `start` that arrives while a transfer is in progress, including its final low half-period, is ignored. Changes to `tx_word` at that time also have no effect.
- R11: After the falling edge that follows the last bit, `sck` and `mosi` are 0. A new `start` is then accepted on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prescale | input | 4 | Prescale modulus; half-period is 2*(prescale+1) cycles |
| char_len | input | 4 | Character size minus one |
| msb_first | input | 1 | 1: most significant bit first, 0: least significant bit first |
| tx_word | input | 16 | Word whose low bits form the outgoing character |
| start | input | 1 | Begins a transfer when idle |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the slave |
| rx_word | output | 16 | Last received character, right-justified |
| done | output | 1 | One-cycle pulse when the last bit is captured |

## Verification
The checker assumes that `start` is a synchronous level sampled on the base clock. It also assumes that `prescale`, `char_len` and `msb_first` matter only in the cycle in which a start is accepted, because the half-period and width checks use values latched at that point. The bench changes configuration inputs only at an idle start. It drives `miso` from a behavioural slave that updates in the cycle after each expected falling edge, so every captured bit is stable at its sampling edge. The stray start strobes and the `tx_word` changes it issues all fall within busy windows, where the block must ignore them.

// File: rtl/spi_char_pkg.sv
package spi_char_pkg;
    localparam int WORD_W  = 16;
    localparam int LEN_W   = 4;
    localparam int PM_W    = 4;
    localparam int IDX_W   = $clog2(WORD_W);
    localparam int NB_W    = IDX_W + 1;
    localparam int MIN_LEN = 3;

    typedef struct packed {
        logic              busy;
        logic              sck;
        logic              mosi;
        logic              done;
        logic              msb;
        logic [PM_W-1:0]   pm;
        logic [NB_W-1:0]   nbits;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] tx;
        logic [WORD_W-1:0] rx_acc;
        logic [WORD_W-1:0] rx_out;
    } seq_state_t;
endpackage

// File: rtl/spi_char_lenclamp.sv
module spi_char_lenclamp #(
    parameter int WORD_W  = 16,
    parameter int LEN_W   = 4,
    parameter int NB_W    = 5,
    parameter int MIN_LEN = 3
) (
    input  logic [LEN_W-1:0]  len_code,
    output logic [NB_W-1:0]   nbits,
    output logic [WORD_W-1:0] mask
);
    localparam logic [LEN_W-1:0] MIN_CODE = LEN_W'(MIN_LEN);

    logic [LEN_W-1:0] code_eff;

    always_comb begin
        code_eff = (len_code < MIN_CODE) ? MIN_CODE : len_code;
        nbits    = NB_W'(code_eff) + NB_W'(1);
    end

    for (genvar i = 0; i < WORD_W; i++) begin : g_mask
        assign mask[i] = (NB_W'(i) < nbits);
    end
endmodule

// File: rtl/spi_char_bitpos.sv
module spi_char_bitpos #(
    parameter int IDX_W = 4,
    parameter int NB_W  = 5
) (
    input  logic [NB_W-1:0]  nbits,
    input  logic             msb_first,
    input  logic [IDX_W-1:0] slot,
    output logic [IDX_W-1:0] pos
);
    logic [NB_W-1:0] from_top;

    always_comb begin
        from_top = nbits - NB_W'(1) - NB_W'(slot);
        pos      = msb_first ? from_top[IDX_W-1:0] : slot;
    end
endmodule

// File: rtl/spi_char_halfdiv.sv
module spi_char_halfdiv #(
    parameter int PM_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic            run,
    input  logic [PM_W-1:0] pm_new,
    input  logic [PM_W-1:0] pm_cur,
    output logic            tick
);
    localparam int CNT_W = PM_W + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = run && (cnt_q == '0);
        if (restart) begin
            cnt_d = {pm_new, 1'b1};
        end else if (run) begin
            cnt_d = (cnt_q == '0) ? {pm_cur, 1'b1} : cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_char_seq.sv
module spi_char_seq
    import spi_char_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tick,
    input  logic              miso,
    input  logic [NB_W-1:0]   nbits_in,
    input  logic              msb_in,
    input  logic [PM_W-1:0]   pm_in,
    input  logic [WORD_W-1:0] tx_in,
    input  logic [IDX_W-1:0]  pos_launch,
    input  logic [IDX_W-1:0]  pos_cur,
    input  logic [IDX_W-1:0]  pos_next,
    output seq_state_t        st_q
);
    seq_state_t st_d;
    logic       last_slot;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        last_slot = (NB_W'(st_q.idx) == st_q.nbits - NB_W'(1));
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy   = 1'b1;
                st_d.sck    = 1'b0;
                st_d.idx    = '0;
                st_d.nbits  = nbits_in;
                st_d.msb    = msb_in;
                st_d.pm     = pm_in;
                st_d.tx     = tx_in;
                st_d.rx_acc = '0;
                st_d.mosi   = tx_in[pos_launch];
            end
        end else if (tick) begin
            if (!st_q.sck) begin
                st_d.sck             = 1'b1;
                st_d.rx_acc[pos_cur] = miso;
                if (last_slot) begin
                    st_d.done   = 1'b1;
                    st_d.rx_out = st_d.rx_acc;
                end
            end else begin
                st_d.sck = 1'b0;
                if (last_slot) begin
                    st_d.busy = 1'b0;
                    st_d.mosi = 1'b0;
                end else begin
                    st_d.idx  = st_q.idx + IDX_W'(1);
                    st_d.mosi = st_q.tx[pos_next];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/spi_char_master.sv
module spi_char_master
    import spi_char_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PM_W-1:0]   prescale,
    input  logic [LEN_W-1:0]  char_len,
    input  logic              msb_first,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              start,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic [WORD_W-1:0] rx_word,
    output logic              done
);
    localparam int N_SEL = 3;

    seq_state_t        st;
    logic [NB_W-1:0]   nbits_in;
    logic [WORD_W-1:0] char_mask;
    logic              launch;
    logic              tick;
    logic              busy_w;
    logic [NB_W-1:0]   nbits_w;

    logic [NB_W-1:0]   sel_nbits [N_SEL];
    logic              sel_msb   [N_SEL];
    logic [IDX_W-1:0]  sel_slot  [N_SEL];
    logic [IDX_W-1:0]  sel_pos   [N_SEL];

    spi_char_lenclamp #(
        .WORD_W(WORD_W), .LEN_W(LEN_W), .NB_W(NB_W), .MIN_LEN(MIN_LEN)
    ) u_len (
        .len_code(char_len), .nbits(nbits_in), .mask(char_mask)
    );

    always_comb begin
        sel_nbits[0] = nbits_in;
        sel_msb[0]   = msb_first;
        sel_slot[0]  = '0;
        sel_nbits[1] = st.nbits;
        sel_msb[1]   = st.msb;
        sel_slot[1]  = st.idx;
        sel_nbits[2] = st.nbits;
        sel_msb[2]   = st.msb;
        sel_slot[2]  = st.idx + IDX_W'(1);
    end

    for (genvar k = 0; k < N_SEL; k++) begin : g_pos
        spi_char_bitpos #(.IDX_W(IDX_W), .NB_W(NB_W)) u_pos (
            .nbits(sel_nbits[k]), .msb_first(sel_msb[k]),
            .slot(sel_slot[k]), .pos(sel_pos[k])
        );
    end

    assign launch = start && !st.busy;

    spi_char_halfdiv #(.PM_W(PM_W)) u_div (
        .clk(clk), .rst_n(rst_n), .restart(launch), .run(st.busy),
        .pm_new(prescale), .pm_cur(st.pm), .tick(tick)
    );

    spi_char_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .tick(tick), .miso(miso),
        .nbits_in(nbits_in), .msb_in(msb_first), .pm_in(prescale),
        .tx_in(tx_word & char_mask),
        .pos_launch(sel_pos[0]), .pos_cur(sel_pos[1]), .pos_next(sel_pos[2]),
        .st_q(st)
    );

    assign sck     = st.sck;
    assign mosi    = st.mosi;
    assign done    = st.done;
    assign rx_word = st.rx_out;
    assign busy_w  = st.busy;
    assign nbits_w = st.nbits;
endmodule

// File: rtl/spi_char_checker.sv
module spi_char_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [3:0]  pm,
    input logic        busy,
    input logic        sck,
    input logic        mosi,
    input logic        done,
    input logic [15:0] rx_word,
    input logic [4:0]  nbits
);
    logic [6:0] run_cnt;
    logic [3:0] pm_lat;
    logic       sck_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt  <= '0;
            pm_lat   <= '0;
            sck_prev <= 1'b0;
        end else begin
            sck_prev <= sck;
            if (!busy && start) begin
                pm_lat  <= pm;
                run_cnt <= '0;
            end else if (busy) begin
                if (sck != sck_prev) begin
                    AST_HALF_PERIOD: assert (int'(run_cnt) == 2 * (int'(pm_lat) + 1))
                        else $error("half period %0d", run_cnt); // R2
                    run_cnt <= 7'd1;
                end else begin
                    run_cnt <= run_cnt + 7'd1;
                end
            end
        end
    end

    AST_IDLE_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !sck); // R11
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
    AST_DONE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n) done |-> $rose(sck)); // R9
    AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n) sck |-> $stable(mosi)); // R7
    AST_RX_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) done |-> ((rx_word >> nbits) == 16'h0)); // R8
    AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !done |=> $stable(rx_word) || done); // R8
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n) (busy && start) |=> (nbits == $past(nbits))); // R10
endmodule

bind spi_char_master spi_char_checker u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .pm(prescale), .busy(busy_w),
    .sck(sck), .mosi(mosi), .done(done), .rx_word(rx_word), .nbits(nbits_w)
);

// File: tb/tb_spi_char_master.sv
module tb_spi_char_master;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  prescale = '0;
    logic [3:0]  char_len = '0;
    logic        msb_first = 1'b0;
    logic [15:0] tx_word = '0;
    logic        start = 1'b0;
    logic        miso = 1'b0;
    logic        sck, mosi, done;
    logic [15:0] rx_word;

    int          total = 0;
    int          bad = 0;
    logic [15:0] rx_model = '0;
    bit          finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_char_master dut (
        .clk(clk), .rst_n(rst_n), .prescale(prescale), .char_len(char_len),
        .msb_first(msb_first), .tx_word(tx_word), .start(start), .miso(miso),
        .sck(sck), .mosi(mosi), .rx_word(rx_word), .done(done)
    );

    task automatic chk(string tag, string what, logic [15:0] got, logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    function automatic int pos_of(int k, int n, bit rev);
        return rev ? (n - 1 - k) : k;
    endfunction

    task automatic xfer(int pm, int len, bit rev, logic [15:0] tx, logic [15:0] s,
                        int ign_at, string tag);
        int n = (len < 3) ? 4 : len + 1;
        int h = 2 * (pm + 1);
        int last_rise = (2 * n - 1) * h;
        int total_e = 2 * n * h;
        logic [15:0] mask = 16'((32'h1 << n) - 1);
        @(negedge clk);
        prescale  = pm[3:0];
        char_len  = len[3:0];
        msb_first = rev;
        tx_word   = tx;
        start     = 1'b1;
        miso      = s[pos_of(0, n, rev)];
        for (int e = 0; e <= total_e; e++) begin
            @(negedge clk);
            start = (e == ign_at);
            if (e == ign_at) tx_word = ~tx;
            if (e == last_rise) rx_model = s & mask;
            chk((e == total_e) ? "R11" : "R2", "sck", {15'b0, sck},
                (e < total_e) ? 16'((e / h) % 2) : 16'h0);
            chk((e == 0) ? "R7" : ((e == total_e) ? "R11" : tag), "mosi", {15'b0, mosi},
                (e < total_e) ? {15'b0, tx[pos_of(e / (2 * h), n, rev)]} : 16'h0);
            chk("R9", "done", {15'b0, done}, 16'(e == last_rise));
            chk("R8", "rx_word", rx_word, rx_model);
            miso = (e < total_e) ? s[pos_of(e / (2 * h), n, rev)] : 1'b0;
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "sck in reset", {15'b0, sck}, 16'h0);
        chk("R1", "mosi in reset", {15'b0, mosi}, 16'h0);
        chk("R1", "done in reset", {15'b0, done}, 16'h0);
        chk("R1", "rx in reset", rx_word, 16'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "sck after reset", {15'b0, sck}, 16'h0);
        chk("R1", "rx after reset", rx_word, 16'h0);

        xfer(0, 7, 1'b0, 16'h00A5, 16'h003C, -1, "R6");
        xfer(0, 7, 1'b1, 16'h00A5, 16'h00C3, -1, "R6");
        xfer(1, 4, 1'b1, 16'hFFE9, 16'hFFF6, -1, "R5");
        xfer(3, 12, 1'b0, 16'h1B5D, 16'hE4A2, -1, "R3");
        xfer(15, 15, 1'b1, 16'h8001, 16'h7FFE, -1, "R3");
        xfer(0, 0, 1'b1, 16'hFFF9, 16'h0006, -1, "R4");
        xfer(1, 2, 1'b0, 16'h000B, 16'hFFF4, -1, "R4");
        xfer(0, 7, 1'b0, 16'h0096, 16'h0069, 5, "R10");
        xfer(1, 5, 1'b1, 16'h0025, 16'h001A, 2 * 6 * 4 - 1, "R10");
        for (int i = 0; i < 8; i++) begin
            xfer(int'($urandom % 3), int'($urandom % 16), 1'($urandom % 2),
                 16'($urandom), 16'($urandom), -1, "R6");
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule